// File: doc/BRIEF.md
# Reduced Lookup Function Generator with Residue Encoding

This block produces any Boolean function of N input variables from a selector that has only half as many data inputs as the truth table has rows. The upper N-1 variables steer a binary selector tree with 2^(N-1) leaves. The lowest variable is not used as a select line. Each leaf instead resolves a 2-bit residue code against it, giving a constant 0, a constant 1, the variable itself, or its inverse.

Software, or a higher-level controller, turns a truth table into one residue code per pair of rows. The pair shares its select values and differs only in the lowest variable. The codes are written through a single-cycle load port and held until the next write. The output is combinational in the variables: it follows the input vector within the same cycle, while the configuration changes only on a clock edge.

Top module: `rlut_core`

## Requirements
- R1: A synchronous active-high reset clears every residue code to 00, so the output is 0 for every input vector until a new load.
- R2: When cfg_we is high at a rising clock edge, cfg_data becomes the configuration from that edge onward. Before that edge the old function still applies. While cfg_we is low, changes on cfg_data have no effect on the output.
- R3: The select index is vars_in[N-1:1], with vars_in[N-1] as its most significant bit. The code for index k sits in cfg_data bits [2k+1:2k].
- R4: Code 00 at the selected index drives the output to 0 whatever vars_in[0] is.
- R5: Code 01 at the selected index drives the output to 1 whatever vars_in[0] is.
- R6: Code 10 at the selected index drives the output to the value of vars_in[0].
- R7: Code 11 at the selected index drives the output to the inverse of vars_in[0].
- R8: For any truth table of N variables whose row number is the value of vars_in, loading its residue decomposition reproduces the table on all 2^N input vectors.
- R9: The output responds to a change of vars_in within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the residue configuration |
| cfg_data | input | 2*2^(N-1) | Residue codes, two bits per selector leaf |
| vars_in | input | N | Input variables; bit 0 is the data variable |
| f_out | output | 1 | Function value for the current input vector |

## Verification
On every clock edge the assertions check the loading and holding of the configuration register and its clearing by reset. They also check the output against the code stored at the index the upper variables pick, for each of the four code meanings. Only the bench scenarios can show the following: that a full decomposed truth table reproduces every row, that the old function holds until the load edge, and that the output follows the variables between edges. The bench also confirms that the field position of each code matches the index order expected by the tables it builds.

// File: rtl/rlut_pkg.sv
package rlut_pkg;

    typedef enum logic [1:0] {
        RES_ZERO = 2'b00,
        RES_ONE  = 2'b01,
        RES_TRUE = 2'b10,
        RES_INV  = 2'b11
    } residue_e;

    function automatic logic resolve_residue(input residue_e code, input logic d);
        logic r;
        case (code)
            RES_ZERO: r = 1'b0;
            RES_ONE:  r = 1'b1;
            RES_TRUE: r = d;
            default:  r = ~d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rlut_cfg_store.sv
module rlut_cfg_store #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] din,
    output logic [CFG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= din;
        end
    end

endmodule

// File: rtl/rlut_residue_resolve.sv
module rlut_residue_resolve
    import rlut_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [2*ENTRIES-1:0] cfg,
    input  logic                 d,
    output logic [ENTRIES-1:0]   leaf
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_leaf
        residue_e code;
        assign code    = residue_e'(cfg[2*i +: 2]);
        assign leaf[i] = resolve_residue(code, d);
    end

endmodule

// File: rtl/rlut_select_tree.sv
module rlut_select_tree #(
    parameter int SEL_W = 3
) (
    input  logic [(1<<SEL_W)-1:0] leaves,
    input  logic [SEL_W-1:0]      sel,
    output logic                  y
);

    localparam int LEAVES = 1 << SEL_W;

    for (genvar l = 0; l <= SEL_W; l++) begin : g_lvl
        localparam int W = LEAVES >> l;
        logic [W-1:0] nodes;
        if (l == 0) begin : g_base
            assign nodes = leaves;
        end else begin : g_mux
            for (genvar j = 0; j < W; j++) begin : g_m
                assign nodes[j] = sel[l-1] ? g_lvl[l-1].nodes[2*j+1]
                                           : g_lvl[l-1].nodes[2*j];
            end
        end
    end

    assign y = g_lvl[SEL_W].nodes[0];

endmodule

// File: rtl/rlut_core.sv
module rlut_core #(
    parameter int N = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [2*(1<<(N-1))-1:0] cfg_data,
    input  logic [N-1:0]            vars_in,
    output logic                    f_out
);

    localparam int SEL_W   = N - 1;
    localparam int ENTRIES = 1 << SEL_W;
    localparam int CFG_W   = 2 * ENTRIES;

    logic [CFG_W-1:0]   cfg_q;
    logic [ENTRIES-1:0] leaf_bits;

    rlut_cfg_store #(.CFG_W(CFG_W)) u_store (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .din (cfg_data),
        .q   (cfg_q)
    );

    rlut_residue_resolve #(.ENTRIES(ENTRIES)) u_resolve (
        .cfg  (cfg_q),
        .d    (vars_in[0]),
        .leaf (leaf_bits)
    );

    rlut_select_tree #(.SEL_W(SEL_W)) u_tree (
        .leaves (leaf_bits),
        .sel    (vars_in[N-1:1]),
        .y      (f_out)
    );

endmodule

// File: rtl/rlut_checks.sv
module rlut_checks #(
    parameter int N = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cfg_we,
    input logic [2*(1<<(N-1))-1:0] cfg_data,
    input logic [N-1:0]            vars_in,
    input logic [2*(1<<(N-1))-1:0] cfg_q,
    input logic                    f_out
);

    localparam int SEL_W = N - 1;

    logic [SEL_W:0] off;
    logic [1:0]     cur_code;
    logic           rst_q;

    assign off      = {vars_in[N-1:1], 1'b0};
    assign cur_code = cfg_q[off +: 2];

    always_ff @(posedge clk) rst_q <= rst;

    // R1: the cycle after a reset edge holds an all-zero configuration
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (cfg_q == '0 && f_out == 1'b0));

    // R2: a load edge captures the data
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == $past(cfg_data)));

    // R2: without the strobe the configuration holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

    // R4
    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_code == 2'b00) |-> (f_out == 1'b0));

    // R5
    p_one_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_code == 2'b01) |-> (f_out == 1'b1));

    // R6
    p_true_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_code == 2'b10) |-> (f_out == vars_in[0]));

    // R7
    p_inv_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_code == 2'b11) |-> (f_out == !vars_in[0]));

endmodule

bind rlut_core rlut_checks #(.N(N)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .vars_in  (vars_in),
    .cfg_q    (cfg_q),
    .f_out    (f_out)
);

// File: tb/tb_rlut_core.sv
`timescale 1ns/1ps
module tb_rlut_core;

    localparam int N       = 4;
    localparam int ROWS    = 1 << N;
    localparam int ENTRIES = 1 << (N - 1);
    localparam int CFG_W   = 2 * ENTRIES;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_we;
    logic [CFG_W-1:0] cfg_data;
    logic [N-1:0]     vars_in;
    logic             f_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    rlut_core #(.N(N)) dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .vars_in  (vars_in),
        .f_out    (f_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s vars=%0d actual=%0b expected=%0b", tag, vars_in, act, exp);
        end
    endtask

    // Split a truth table into row pairs: even row has data var 0, odd row 1.
    function automatic logic [CFG_W-1:0] decompose(input logic [ROWS-1:0] tt);
        logic [CFG_W-1:0] c;
        c = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            case ({tt[2*k+1], tt[2*k]})
                2'b00:   c[2*k +: 2] = 2'b00;
                2'b11:   c[2*k +: 2] = 2'b01;
                2'b10:   c[2*k +: 2] = 2'b10;
                default: c[2*k +: 2] = 2'b11;
            endcase
        end
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] fill(input logic [1:0] code);
        logic [CFG_W-1:0] c;
        for (int k = 0; k < ENTRIES; k++) c[2*k +: 2] = code;
        return c;
    endfunction

    task automatic load(input logic [CFG_W-1:0] c);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_data = c;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // R9: vars_in changes between edges and the output is sampled 1 ns later
    task automatic sweep(input logic [ROWS-1:0] tt, input string tag);
        for (int v = 0; v < ROWS; v++) begin
            vars_in = v[N-1:0];
            #1;
            check(tag, f_out, tt[v]);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0]      lfsr;
        logic [ROWS-1:0]  tt;
        rst      = 1'b1;
        cfg_we   = 1'b0;
        cfg_data = '0;
        vars_in  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        sweep('0, "R1 reset state");

        load(fill(2'b00)); sweep('0, "R4 code 00");
        load(fill(2'b01)); sweep({ROWS{1'b1}}, "R5 code 01");
        load(fill(2'b10)); sweep({(ROWS/2){2'b10}}, "R6 code 10");
        load(fill(2'b11)); sweep({(ROWS/2){2'b01}}, "R7 code 11");

        // R3: a single entry at index k set to constant 1
        for (int k = 0; k < ENTRIES; k++) begin
            logic [CFG_W-1:0] c;
            c = '0;
            c[2*k +: 2] = 2'b01;
            load(c);
            sweep({{(ROWS-2){1'b0}}, 2'b11} << (2*k), "R3 index order");
        end

        // R2: old function until the load edge, new one after it
        load(fill(2'b00));
        @(negedge clk);
        vars_in  = 4'd9;
        cfg_we   = 1'b1;
        cfg_data = fill(2'b01);
        #1 check("R2 before load edge", f_out, 1'b0);
        @(posedge clk);
        #1 check("R2 after load edge", f_out, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0;

        // R2: cfg_data ignored while the strobe is low
        load(fill(2'b10));
        @(negedge clk);
        cfg_data = fill(2'b11);
        repeat (3) @(negedge clk);
        sweep({(ROWS/2){2'b10}}, "R2 hold without strobe");

        // R8: decomposed pseudo-random truth tables
        lfsr = 16'hACE1;
        for (int t = 0; t < 40; t++) begin
            for (int s = 0; s < 16; s++)
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tt = lfsr[ROWS-1:0];
            load(decompose(tt));
            sweep(tt, "R8 random table");
        end

        // R1: reset during operation clears the loaded function
        load(fill(2'b01));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        sweep('0, "R1 reset after load");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule